// File: doc/BRIEF.md
# LCD Common Scan and Blink Timer

This block turns a raw oscillator tick into the internal logic clock enable of a dot-matrix LCD controller. From that enable it produces the scan of the common lines, a frame-rate toggle for AC drive alternation, a slow blink phase and a pulse that marks the window in which a command is allowed to finish.

In crystal mode every oscillator tick becomes an internal clock enable. In external-clock mode a 2-bit code selects a prescale of 2, 4, 8 or 16. A duty select picks between a 9-common scan and a 17-common scan. The line length changes with the duty so that both frame rates sit near 65 to 69 Hz at a 32.768 kHz internal clock. A stop request freezes the enable and all timing state. Display-off only blanks the common select and leaves every counter running.

Top module: `lcd_scan_timer`

## Requirements
- R1: With `ext_mode` low, each `osc_tick` that is not held off by `stop_req` produces exactly one `clk_en` pulse, one cycle later.
- R2: With `ext_mode` high, `clk_en` pulses once per 2, 4, 8 or 16 ticks for `div_sel` values 0, 1, 2 and 3, so any 64 consecutive ticks give 32, 16, 8 or 4 pulses.
- R3: `com_idx` advances by one after 56 internal clock enables per line when `duty17` is 0, and after 28 per line when `duty17` is 1.
- R4: `com_idx` runs 0 to 8 when `duty17` is 0 and 0 to 16 when `duty17` is 1, then returns to 0.
- R5: `frame_tog` inverts at each return of `com_idx` to 0, so it first inverts after 504 enables at the 9-common scan and after 476 at the 17-common scan.
- R6: `blink` inverts once every 16384 internal clock enables.
- R7: `exec_pulse` is high for one cycle at the end of every second common line, first after two full lines.
- R8: While `stop_req` is high, `clk_en` stays low, `com_idx`, `frame_tog` and `blink` hold, and `com_sel` is all zero. Scanning resumes after release.
- R9: With `disp_on` low, `com_sel` is all zero while `clk_en` keeps pulsing.
- R10: After reset, `clk_en`, `com_idx`, `frame_tog`, `blink` and `exec_pulse` are all 0.
- R11: With `disp_on` high and `stop_req` low, `com_sel` has exactly bit `com_idx` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| ext_mode | input | 1 | 1: external clock with prescale; 0: crystal, undivided |
| div_sel | input | 2 | Prescale code: 0 gives /2, 1 gives /4, 2 gives /8, 3 gives /16 |
| duty17 | input | 1 | 1: 17-common scan; 0: 9-common scan |
| stop_req | input | 1 | Halts the internal clock and all timing state |
| disp_on | input | 1 | Enables the common select output |
| clk_en | output | 1 | Internal logic clock enable |
| com_idx | output | 5 | Index of the active common line |
| com_sel | output | 17 | One-hot select of the active common, zero when blanked |
| frame_tog | output | 1 | AC alternation toggle, inverts per frame |
| blink | output | 1 | Blink phase |
| exec_pulse | output | 1 | Marks the end of each two-line command window |

## Verification
The assertions assume that `duty17` changes only while the block is in reset. For that reason, the range check on the 9-common scan applies only when the duty held steady in the previous cycle. The assertions also assume that `osc_tick` is a plain level sampled per clock and needs no spacing. The bench picks the duty and the mode before it releases reset for each scan measurement. It drives every input on falling edges, and it keeps ticks continuous inside each measuring window, so the counted enables map directly to line, frame and blink lengths.

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer #(
  parameter int NCOM       = 17,
  parameter int LINE_LO    = 56,
  parameter int LINE_HI    = 28,
  parameter int BLINK_HALF = 16384
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            osc_tick,
  input  logic            ext_mode,
  input  logic [1:0]      div_sel,
  input  logic            duty17,
  input  logic            stop_req,
  input  logic            disp_on,
  output logic            clk_en,
  output logic [4:0]      com_idx,
  output logic [NCOM-1:0] com_sel,
  output logic            frame_tog,
  output logic            blink,
  output logic            exec_pulse
);
  localparam int NCOM_LO = (NCOM + 1) / 2;
  localparam int LW      = $clog2(LINE_LO + 1);
  localparam int BW      = $clog2(BLINK_HALF);

  logic [3:0]    pre_cnt;
  logic [3:0]    pre_mask;
  logic [LW-1:0] line_cnt;
  logic [BW-1:0] blink_cnt;
  logic          pair;

  always_comb
    case (div_sel)
      2'd0:    pre_mask = 4'h1;
      2'd1:    pre_mask = 4'h3;
      2'd2:    pre_mask = 4'h7;
      default: pre_mask = 4'hF;
    endcase

  wire pre_hit  = !ext_mode || ((pre_cnt & pre_mask) == pre_mask);
  wire adv      = clk_en && !stop_req;
  wire [LW-1:0] line_last = duty17 ? LW'(LINE_HI - 1) : LW'(LINE_LO - 1);
  wire [4:0]    com_last  = duty17 ? 5'(NCOM - 1) : 5'(NCOM_LO - 1);
  wire line_end = adv && (line_cnt >= line_last);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre_cnt <= '0;
      clk_en  <= 1'b0;
    end else begin
      clk_en <= osc_tick && !stop_req && pre_hit;
      if (osc_tick && !stop_req) pre_cnt <= pre_cnt + 4'd1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      line_cnt   <= '0;
      com_idx    <= '0;
      frame_tog  <= 1'b0;
      pair       <= 1'b0;
      exec_pulse <= 1'b0;
    end else begin
      exec_pulse <= line_end && pair;
      if (line_end) begin
        line_cnt <= '0;
        pair     <= !pair;
        if (com_idx >= com_last) begin
          com_idx   <= '0;
          frame_tog <= !frame_tog;
        end else begin
          com_idx <= com_idx + 5'd1;
        end
      end else if (adv) begin
        line_cnt <= line_cnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      blink_cnt <= '0;
      blink     <= 1'b0;
    end else if (adv) begin
      if (blink_cnt == BW'(BLINK_HALF - 1)) begin
        blink_cnt <= '0;
        blink     <= !blink;
      end else begin
        blink_cnt <= blink_cnt + 1'b1;
      end
    end

  assign com_sel = (disp_on && !stop_req) ? (NCOM'(1) << com_idx) : '0;

  a_r1_xtal_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && !stop_req && osc_tick) |=> clk_en);
  a_r8_stop_gate: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !clk_en);
  a_r8_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && $past(stop_req)) |-> ($stable(com_idx) && $stable(frame_tog) && $stable(blink)));
  a_r3_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(com_idx) |-> (com_idx == $past(com_idx) + 5'd1 || com_idx == 5'd0));
  a_r4_range_hi: assert property (@(posedge clk) disable iff (!rst_n)
    com_idx <= 5'(NCOM - 1));
  a_r4_range_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (!duty17 && !$past(duty17) && $past(com_idx) <= 5'(NCOM_LO - 1)) |-> com_idx <= 5'(NCOM_LO - 1));
  a_r5_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frame_tog) |-> com_idx == 5'd0);
  a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(com_sel));
endmodule

// File: tb/tb_lcd_scan_timer.sv
`timescale 1ns/1ps
module tb_lcd_scan_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic osc_tick = 1'b0, ext_mode = 1'b0, duty17 = 1'b0, stop_req = 1'b0, disp_on = 1'b1;
  logic [1:0] div_sel = 2'd0;
  logic clk_en, frame_tog, blink, exec_pulse;
  logic [4:0] com_idx;
  logic [16:0] com_sel;
  int errs = 0, checks = 0, en_cnt = 0;

  always #2.5 clk = !clk;

  lcd_scan_timer dut (.clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .ext_mode(ext_mode),
    .div_sel(div_sel), .duty17(duty17), .stop_req(stop_req), .disp_on(disp_on),
    .clk_en(clk_en), .com_idx(com_idx), .com_sel(com_sel), .frame_tog(frame_tog),
    .blink(blink), .exec_pulse(exec_pulse));

  always @(negedge clk) if (clk_en) en_cnt <= en_cnt + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic t_reset(input bit d17, input bit em);
    osc_tick = 1'b0; stop_req = 1'b0; disp_on = 1'b1;
    duty17 = d17; ext_mode = em;
    rst_n = 1'b0;
    repeat (3) step();
    chk(clk_en == 0 && com_idx == 0 && frame_tog == 0 && blink == 0 && exec_pulse == 0,
        "R10 reset state", {clk_en, com_idx, frame_tog, blink, exec_pulse}, 0);
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_rate(input bit em, input int code, input int expn, input string req);
    int base;
    ext_mode = em; div_sel = 2'(code);
    step();
    base = en_cnt;
    osc_tick = 1'b1;
    repeat (64) step();
    osc_tick = 1'b0;
    repeat (3) step();
    chk(en_cnt - base == expn, req, en_cnt - base, expn);
  endtask

  // The enable issued in the sampling cycle is already counted, hence the +1.
  task automatic t_scan(input bit d17);
    int base, len, lines, maxi, at_line, at_exec, at_frame, sel_bad, wrap_idx;
    len = d17 ? 28 : 56; lines = d17 ? 17 : 9;
    t_reset(d17, 1'b0);
    base = en_cnt; maxi = 0; at_line = -1; at_exec = -1; at_frame = -1; sel_bad = 0; wrap_idx = -1;
    osc_tick = 1'b1;
    for (int i = 0; i < 2000 && at_frame < 0; i++) begin
      step();
      if (com_idx > maxi) maxi = com_idx;
      if (at_line < 0 && com_idx == 1) at_line = en_cnt - base;
      if (at_exec < 0 && exec_pulse) at_exec = en_cnt - base;
      if (frame_tog) begin at_frame = en_cnt - base; wrap_idx = com_idx; end
      if (com_sel != (17'd1 << com_idx)) sel_bad++;
    end
    osc_tick = 1'b0;
    chk(at_line == len + 1, "R3 line length", at_line, len + 1);
    chk(maxi == lines - 1, "R4 last common index", maxi, lines - 1);
    chk(wrap_idx == 0, "R4 wrap to zero", wrap_idx, 0);
    chk(at_frame == len * lines + 1, "R5 frame toggle", at_frame, len * lines + 1);
    chk(at_exec == 2 * len + 1, "R7 exec window", at_exec, 2 * len + 1);
    chk(sel_bad == 0, "R11 one-hot select", sel_bad, 0);
  endtask

  task automatic t_blink();
    int base, at;
    t_reset(1'b1, 1'b0);
    base = en_cnt; at = -1;
    osc_tick = 1'b1;
    for (int i = 0; i < 20000 && at < 0; i++) begin
      step();
      if (blink) at = en_cnt - base;
    end
    osc_tick = 1'b0;
    chk(at == 16385, "R6 blink half period", at, 16385);
  endtask

  task automatic t_stop();
    int e0, bad;
    logic [4:0] i0;
    logic f0, b0;
    t_reset(1'b1, 1'b0);
    osc_tick = 1'b1;
    repeat (100) step();
    stop_req = 1'b1;
    repeat (2) step();
    e0 = en_cnt; i0 = com_idx; f0 = frame_tog; b0 = blink; bad = 0;
    for (int i = 0; i < 200; i++) begin
      step();
      if (com_sel != 0) bad++;
    end
    chk(en_cnt == e0, "R8 no enables while stopped", en_cnt - e0, 0);
    chk(com_idx == i0 && frame_tog == f0 && blink == b0, "R8 state held", com_idx, i0);
    chk(bad == 0, "R8 select blanked", bad, 0);
    stop_req = 1'b0;
    repeat (100) step();
    chk(en_cnt - e0 >= 98, "R8 resume after release", en_cnt - e0, 99);
    osc_tick = 1'b0;
  endtask

  task automatic t_dispoff();
    int e0, bad;
    t_reset(1'b0, 1'b0);
    osc_tick = 1'b1;
    disp_on = 1'b0;
    step();
    e0 = en_cnt; bad = 0;
    for (int i = 0; i < 50; i++) begin
      step();
      if (com_sel != 0) bad++;
    end
    chk(bad == 0, "R9 select blanked when off", bad, 0);
    chk(en_cnt - e0 == 50, "R9 clock keeps running", en_cnt - e0, 50);
    osc_tick = 1'b0; disp_on = 1'b1;
  endtask

  initial begin
    #2000000;
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    t_reset(1'b0, 1'b0);
    t_rate(1'b0, 0, 64, "R1 crystal undivided");
    t_rate(1'b1, 0, 32, "R2 divide by 2");
    t_rate(1'b1, 1, 16, "R2 divide by 4");
    t_rate(1'b1, 2, 8,  "R2 divide by 8");
    t_rate(1'b1, 3, 4,  "R2 divide by 16");
    t_scan(1'b0);
    t_scan(1'b1);
    t_blink();
    t_stop();
    t_dispoff();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule